// File: doc/BRIEF.md
# Cross-Context Register Access Decoder

This block serves privileged move-from and move-to operations that reach into a register held by another hardware thread context. A request carries the operation direction, the unit bit, the selector, both register-number fields, the extension field `rx` and the half bit. It also carries the target context number and the requester's VPE number and master right. The block turns these into a register bank code, an index and a context number for the register banks. It either raises a write enable with shaped write data, or it shapes the word the banks return into the read result.

Access rights are checked against each context's VPE binding and against the highest implemented context. A refused read returns all ones and a refused write is dropped. Selections with no register behind them raise a reserved flag, read as zero and write nothing. Narrow sources are sign-extended on reads. On writes to narrow targets the value is truncated, not sign-extended. For 64-bit registers the half bit picks the 32-bit half.

Top module: `xctx_access`

## Requirements
- R1: A request sampled with `req_i` high at a rising clock edge shows its result on the outputs in the next clock cycle. A cycle with no request presents `bank_o`=0, `we_o`=0, `rvalid_o`=0, `rsvd_o`=0 and `rdata_o`=0.
- R2: With `u_i`=0 the target is bank 1 (system control registers), and `idx_o` = register number * 8 + `sel_i`.
- R3: With `u_i`=1: `sel_i`=0 selects bank 2 (general), `sel_i`=2 selects bank 5 (64-bit floating point) and `sel_i`=3 selects bank 6 (floating-point control). Each uses `idx_o` = register number.
- R4: With `u_i`=1 and `sel_i`=1, register numbers whose low two bits are 0, 1 or 2 and whose value is below 16 select bank 3 (accumulators) with `idx_o` = register number. Low bits 2 select the 8-bit extension part, and a read of it is sign-extended from bit 7. Register number 16 selects bank 4 (DSP control) with `idx_o`=0.
- R5: With `u_i`=1, `sel_i`=4 selects bank 7 (64-bit coprocessor-2 data) and `sel_i`=5 selects bank 8 (coprocessor-2 control). Both use `idx_o` = `rx_i` * 32 + register number.
- R6: A read returns all ones with `bank_o`=0 in either of two cases: the target context number is above `LAST_TC` (default 5), or `req_master_i` is 0 and the target context is bound to a VPE other than `req_vpe_i`.
- R7: Under the R6 conditions a write gives `we_o`=0 and `bank_o`=0.
- R8: The register number is taken from `rt_i` on reads (`op_wr_i`=0) and from `rd_i` on writes (`op_wr_i`=1).
- R9: For banks 5 and 7, `half_o` = `h_i`, and a read returns bits 63:32 of `bank_rdata_i` when `h_i`=1 and bits 31:0 when it is 0. For every other bank `half_o`=0, and a read returns bits 31:0 regardless of `h_i`.
- R10: Write data reaches `wdata_o` unchanged, except for an accumulator extension part: there bits 31:8 are zero and no sign extension takes place.
- R11: Reserved selections raise `rsvd_o`=1 with `bank_o`=0, `we_o`=0 and a read result of 0. These are `sel_i`=1 with register number low bits 3 or number above 16, and `sel_i` of 6 or 7.
- R12: With `req_master_i`=1, a target context bound to another VPE but within `LAST_TC` is accessed normally, and `tc_o` carries the target context number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| op_wr_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| u_i | input | 1 | Unit bit: 0 system control, 1 other classes |
| sel_i | input | SEL_W | Selector field |
| rt_i | input | RNUM_W | Register number used by reads |
| rd_i | input | RNUM_W | Register number used by writes |
| rx_i | input | RNUM_W | Upper index for coprocessor-2 registers |
| h_i | input | 1 | Half select for 64-bit registers |
| targ_tc_i | input | TC_W | Target context number |
| req_vpe_i | input | VPE_W | Requester's VPE number |
| req_master_i | input | 1 | Requester holds master rights |
| tc_bind_i | input | NUM_TC*VPE_W | VPE binding of each context |
| wr_gpr_i | input | XLEN | Value to write |
| bank_rdata_i | input | 2*XLEN | Data returned by the addressed bank |
| bank_o | output | 4 | Bank code, 0 = none |
| tc_o | output | TC_W | Context addressed in the bank |
| idx_o | output | 2*RNUM_W | Register index within the bank |
| half_o | output | 1 | Upper half of a 64-bit register |
| we_o | output | 1 | Write enable |
| wdata_o | output | XLEN | Shaped write data |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | XLEN | Read result |
| rsvd_o | output | 1 | Reserved selection flag |

## Verification
A wrong decode shows in `bank_o` and `idx_o` in the cycle after the request. A faulty access check appears at once as an all-ones read or a missing write enable. Width shaping errors surface in `rdata_o` or `wdata_o` in that same cycle. No state persists past one request, so each fault is visible one cycle after its cause and never later.

// File: rtl/xctx_pkg.sv
package xctx_pkg;
  typedef enum logic [3:0] {
    BK_NONE = 4'd0,
    BK_CP0  = 4'd1,
    BK_GPR  = 4'd2,
    BK_ACC  = 4'd3,
    BK_DSPC = 4'd4,
    BK_FPR  = 4'd5,
    BK_FPCR = 4'd6,
    BK_C2D  = 4'd7,
    BK_C2C  = 4'd8
  } bank_e;

  typedef enum logic [1:0] {
    WD_STD    = 2'd0,
    WD_NARROW = 2'd1,
    WD_WIDE   = 2'd2
  } width_e;
endpackage

// File: rtl/xctx_decode.sv
module xctx_decode
  import xctx_pkg::*;
#(
  parameter int RNUM_W = 5,
  parameter int SEL_W  = 3,
  parameter int IDX_W  = 2 * RNUM_W
) (
  input  logic              u_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [RNUM_W-1:0] rnum_i,
  input  logic [RNUM_W-1:0] rx_i,
  output bank_e             bank_o,
  output logic [IDX_W-1:0]  idx_o,
  output width_e            width_o,
  output logic              rsvd_o
);
  localparam logic [RNUM_W-1:0] DSPC_NUM = RNUM_W'(16);

  always_comb begin
    bank_o  = BK_NONE;
    idx_o   = '0;
    width_o = WD_STD;
    rsvd_o  = 1'b0;
    if (!u_i) begin
      bank_o = BK_CP0;
      idx_o  = IDX_W'({rnum_i, sel_i});
    end else begin
      case (sel_i)
        SEL_W'(0): begin bank_o = BK_GPR; idx_o = IDX_W'(rnum_i); end
        SEL_W'(1): begin
          if (rnum_i < DSPC_NUM) begin
            if (rnum_i[1:0] == 2'b11) rsvd_o = 1'b1;
            else begin
              bank_o = BK_ACC;
              idx_o  = IDX_W'(rnum_i);
              if (rnum_i[1:0] == 2'b10) width_o = WD_NARROW;
            end
          end else if (rnum_i == DSPC_NUM) begin
            bank_o = BK_DSPC;
          end else begin
            rsvd_o = 1'b1;
          end
        end
        SEL_W'(2): begin bank_o = BK_FPR;  idx_o = IDX_W'(rnum_i); width_o = WD_WIDE; end
        SEL_W'(3): begin bank_o = BK_FPCR; idx_o = IDX_W'(rnum_i); end
        SEL_W'(4): begin bank_o = BK_C2D;  idx_o = IDX_W'({rx_i, rnum_i}); width_o = WD_WIDE; end
        SEL_W'(5): begin bank_o = BK_C2C;  idx_o = IDX_W'({rx_i, rnum_i}); end
        default:   rsvd_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/xctx_guard.sv
module xctx_guard #(
  parameter int TC_W    = 3,
  parameter int VPE_W   = 2,
  parameter int NUM_TC  = 1 << TC_W,
  parameter int LAST_TC = 5
) (
  input  logic [TC_W-1:0]          targ_tc_i,
  input  logic [VPE_W-1:0]         req_vpe_i,
  input  logic                     req_master_i,
  input  logic [NUM_TC*VPE_W-1:0]  tc_bind_i,
  output logic                     deny_o
);
  logic [VPE_W-1:0] bind_a [NUM_TC];

  for (genvar t = 0; t < NUM_TC; t++) begin : g_bind
    assign bind_a[t] = tc_bind_i[t*VPE_W +: VPE_W];
  end

  logic out_of_range, foreign;
  assign out_of_range = targ_tc_i > TC_W'(LAST_TC);
  assign foreign      = !req_master_i && (bind_a[targ_tc_i] != req_vpe_i);
  assign deny_o       = out_of_range || foreign;
endmodule

// File: rtl/xctx_shape.sv
module xctx_shape
  import xctx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 8
) (
  input  width_e            width_i,
  input  logic              half_i,
  input  logic [2*XLEN-1:0] bank_rdata_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   rd_shaped_o,
  output logic [XLEN-1:0]   wr_shaped_o
);
  localparam int PAD_W = XLEN - NARROW_W;

  always_comb begin
    case (width_i)
      WD_WIDE:   rd_shaped_o = half_i ? bank_rdata_i[2*XLEN-1:XLEN] : bank_rdata_i[XLEN-1:0];
      WD_NARROW: rd_shaped_o = {{PAD_W{bank_rdata_i[NARROW_W-1]}}, bank_rdata_i[NARROW_W-1:0]};
      default:   rd_shaped_o = bank_rdata_i[XLEN-1:0];
    endcase
    // narrow targets are truncated, never sign-extended
    if (width_i == WD_NARROW) wr_shaped_o = {{PAD_W{1'b0}}, wr_data_i[NARROW_W-1:0]};
    else                      wr_shaped_o = wr_data_i;
  end
endmodule

// File: rtl/xctx_access.sv
module xctx_access
  import xctx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 8,
  parameter int TC_W     = 3,
  parameter int VPE_W    = 2,
  parameter int LAST_TC  = 5,
  parameter int RNUM_W   = 5,
  parameter int SEL_W    = 3,
  localparam int NUM_TC  = 1 << TC_W,
  localparam int IDX_W   = 2 * RNUM_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    op_wr_i,
  input  logic                    u_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [RNUM_W-1:0]       rt_i,
  input  logic [RNUM_W-1:0]       rd_i,
  input  logic [RNUM_W-1:0]       rx_i,
  input  logic                    h_i,
  input  logic [TC_W-1:0]         targ_tc_i,
  input  logic [VPE_W-1:0]        req_vpe_i,
  input  logic                    req_master_i,
  input  logic [NUM_TC*VPE_W-1:0] tc_bind_i,
  input  logic [XLEN-1:0]         wr_gpr_i,
  input  logic [2*XLEN-1:0]       bank_rdata_i,
  output logic [3:0]              bank_o,
  output logic [TC_W-1:0]         tc_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    half_o,
  output logic                    we_o,
  output logic [XLEN-1:0]         wdata_o,
  output logic                    rvalid_o,
  output logic [XLEN-1:0]         rdata_o,
  output logic                    rsvd_o
);
  logic [RNUM_W-1:0] rnum;
  bank_e             dec_bank;
  logic [IDX_W-1:0]  dec_idx;
  width_e            dec_width;
  logic              dec_rsvd, deny, ok;

  assign rnum = op_wr_i ? rd_i : rt_i;

  xctx_decode #(.RNUM_W(RNUM_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_dec (
    .u_i(u_i), .sel_i(sel_i), .rnum_i(rnum), .rx_i(rx_i),
    .bank_o(dec_bank), .idx_o(dec_idx), .width_o(dec_width), .rsvd_o(dec_rsvd)
  );

  xctx_guard #(.TC_W(TC_W), .VPE_W(VPE_W), .NUM_TC(NUM_TC), .LAST_TC(LAST_TC)) u_guard (
    .targ_tc_i(targ_tc_i), .req_vpe_i(req_vpe_i), .req_master_i(req_master_i),
    .tc_bind_i(tc_bind_i), .deny_o(deny)
  );

  assign ok = req_i && !deny && !dec_rsvd;

  logic             valid_q, wr_q, deny_q, rsvd_q, half_q;
  bank_e            bank_q;
  logic [IDX_W-1:0] idx_q;
  logic [TC_W-1:0]  tc_q;
  width_e           width_q;
  logic [XLEN-1:0]  wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      deny_q  <= 1'b0;
      rsvd_q  <= 1'b0;
      half_q  <= 1'b0;
      bank_q  <= BK_NONE;
      idx_q   <= '0;
      tc_q    <= '0;
      width_q <= WD_STD;
      wdata_q <= '0;
    end else begin
      valid_q <= req_i;
      wr_q    <= req_i && op_wr_i;
      deny_q  <= req_i && deny;
      rsvd_q  <= req_i && !deny && dec_rsvd;
      half_q  <= ok && (dec_width == WD_WIDE) && h_i;
      bank_q  <= ok ? dec_bank : BK_NONE;
      idx_q   <= ok ? dec_idx : '0;
      tc_q    <= ok ? targ_tc_i : '0;
      width_q <= ok ? dec_width : WD_STD;
      wdata_q <= (ok && op_wr_i) ? wr_gpr_i : '0;
    end
  end

  logic [XLEN-1:0] rd_shaped, wr_shaped;

  xctx_shape #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_shape (
    .width_i(width_q), .half_i(half_q), .bank_rdata_i(bank_rdata_i),
    .wr_data_i(wdata_q), .rd_shaped_o(rd_shaped), .wr_shaped_o(wr_shaped)
  );

  assign bank_o   = bank_q;
  assign tc_o     = tc_q;
  assign idx_o    = idx_q;
  assign half_o   = half_q;
  assign rsvd_o   = rsvd_q;
  assign we_o     = valid_q && wr_q && (bank_q != BK_NONE);
  assign wdata_o  = we_o ? wr_shaped : '0;
  assign rvalid_o = valid_q && !wr_q;

  always_comb begin
    if (!rvalid_o)              rdata_o = '0;
    else if (deny_q)            rdata_o = '1;
    else if (rsvd_q)            rdata_o = '0;
    else                        rdata_o = rd_shaped;
  end
endmodule

// File: rtl/xctx_access_chk.sv
module xctx_access_chk #(
  parameter int XLEN     = 32,
  parameter int NARROW_W = 8,
  parameter int TC_W     = 3,
  parameter int LAST_TC  = 5,
  parameter int IDX_W    = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             op_wr_i,
  input logic             u_i,
  input logic             req_master_i,
  input logic [TC_W-1:0]  targ_tc_i,
  input logic [3:0]       bank_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             half_o,
  input logic             we_o,
  input logic [XLEN-1:0]  wdata_o,
  input logic             rvalid_o,
  input logic [XLEN-1:0]  rdata_o,
  input logic             rsvd_o
);
  logic out_rng;
  assign out_rng = targ_tc_i > TC_W'(LAST_TC);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !we_o && !rvalid_o && !rsvd_o);

  a_r1_single_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && rvalid_o));

  a_r2_u0_system_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !u_i && req_master_i && !out_rng |=> bank_o == 4'd1);

  a_r4_extension_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && bank_o == 4'd3 && idx_o[1:0] == 2'b10 |->
      (rdata_o[XLEN-1:NARROW_W-1] == '0) || (rdata_o[XLEN-1:NARROW_W-1] == '1));

  a_r6_range_read_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !op_wr_i && out_rng |=> rvalid_o && rdata_o == '1 && bank_o == 4'd0);

  a_r7_range_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && op_wr_i && out_rng |=> !we_o && bank_o == 4'd0);

  a_r9_half_wide_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> (bank_o == 4'd5 || bank_o == 4'd7));

  a_r10_extension_write_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && bank_o == 4'd3 && idx_o[1:0] == 2'b10 |-> wdata_o[XLEN-1:NARROW_W] == '0);

  a_r11_reserved_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> !we_o && bank_o == 4'd0 && rdata_o == '0);
endmodule

bind xctx_access xctx_access_chk #(
  .XLEN(XLEN), .NARROW_W(NARROW_W), .TC_W(TC_W), .LAST_TC(LAST_TC), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/xctx_access_test.sv
module xctx_access_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, op_wr = 1'b0, u = 1'b0, h = 1'b0, master = 1'b0;
  logic [2:0]  sel = '0;
  logic [4:0]  rt = '0, rd = '0, rx = '0;
  logic [2:0]  targ = '0;
  logic [1:0]  vpe = '0;
  logic [15:0] tc_bind;
  logic [31:0] wr_gpr = '0;
  logic [63:0] bank_rdata = 64'h1357_9BDF_2468_AC9C;

  logic [3:0]  bank;
  logic [2:0]  tc;
  logic [9:0]  idx;
  logic        half, we, rvalid, rsvd;
  logic [31:0] wdata, rdata;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xctx_access uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_wr_i(op_wr), .u_i(u), .sel_i(sel),
    .rt_i(rt), .rd_i(rd), .rx_i(rx), .h_i(h), .targ_tc_i(targ), .req_vpe_i(vpe),
    .req_master_i(master), .tc_bind_i(tc_bind), .wr_gpr_i(wr_gpr), .bank_rdata_i(bank_rdata),
    .bank_o(bank), .tc_o(tc), .idx_o(idx), .half_o(half), .we_o(we), .wdata_o(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .rsvd_o(rsvd)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // drive at a falling edge, sample one cycle later at the next falling edge
  task automatic op(input logic w, input logic uu, input logic [2:0] s, input logic [4:0] t_rt,
                    input logic [4:0] t_rd, input logic [4:0] t_rx, input logic hh,
                    input logic [2:0] tt, input logic [1:0] vv, input logic mm, input logic [31:0] wd);
    @(negedge clk);
    req = 1'b1; op_wr = w; u = uu; sel = s; rt = t_rt; rd = t_rd; rx = t_rx; h = hh;
    targ = tt; vpe = vv; master = mm; wr_gpr = wd;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "bank after reset", 64'(bank), 0);
    chk("R1", "we after reset", 64'(we), 0);
    chk("R1", "rvalid after reset", 64'(rvalid), 0);
    chk("R1", "rsvd after reset", 64'(rsvd), 0);
  endtask

  task automatic t_system;
    op(0, 0, 3'd3, 5'd12, 5'd7, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R2", "read bank", 64'(bank), 1);
    chk("R8", "read index from rt", 64'(idx), 99);
    chk("R1", "rvalid", 64'(rvalid), 1);
    chk("R2", "read data", 64'(rdata), 64'h2468AC9C);
    op(1, 0, 3'd1, 5'd4, 5'd9, 5'd0, 0, 3'd2, 2'd0, 0, 32'hCAFE_0001);
    chk("R8", "write index from rd", 64'(idx), 73);
    chk("R2", "write enable", 64'(we), 1);
    chk("R10", "write data", 64'(wdata), 64'hCAFE0001);
    chk("R12", "context out", 64'(tc), 2);
  endtask

  task automatic t_gpr_fp;
    op(0, 1, 3'd0, 5'd17, 5'd0, 5'd0, 1, 3'd0, 2'd0, 0, 0);
    chk("R3", "general bank", 64'(bank), 2);
    chk("R3", "general index", 64'(idx), 17);
    chk("R9", "no half on general", 64'(half), 0);
    chk("R9", "general read ignores h", 64'(rdata), 64'h2468AC9C);
    op(0, 1, 3'd2, 5'd3, 5'd0, 5'd0, 1, 3'd0, 2'd0, 0, 0);
    chk("R3", "fp bank", 64'(bank), 5);
    chk("R9", "fp half flag", 64'(half), 1);
    chk("R9", "fp upper half", 64'(rdata), 64'h13579BDF);
    op(0, 1, 3'd2, 5'd3, 5'd0, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R9", "fp lower half", 64'(rdata), 64'h2468AC9C);
    op(0, 1, 3'd3, 5'd31, 5'd0, 5'd0, 1, 3'd0, 2'd0, 0, 0);
    chk("R3", "fp control bank", 64'(bank), 6);
    chk("R9", "fp control half flag", 64'(half), 0);
  endtask

  task automatic t_acc;
    op(0, 1, 3'd1, 5'd5, 5'd0, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R4", "acc bank", 64'(bank), 3);
    chk("R4", "acc index", 64'(idx), 5);
    op(0, 1, 3'd1, 5'd10, 5'd0, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R4", "extension sign-extended", 64'(rdata), 64'hFFFFFF9C);
    op(0, 1, 3'd1, 5'd16, 5'd0, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R4", "dsp control bank", 64'(bank), 4);
    chk("R4", "dsp control index", 64'(idx), 0);
    op(1, 1, 3'd1, 5'd0, 5'd6, 5'd0, 0, 3'd0, 2'd0, 0, 32'hFFFF_FF85);
    chk("R10", "extension write truncated", 64'(wdata), 64'h85);
    chk("R10", "extension write enable", 64'(we), 1);
    op(1, 1, 3'd0, 5'd0, 5'd6, 5'd0, 0, 3'd0, 2'd0, 0, 32'hFFFF_FF85);
    chk("R10", "general write unchanged", 64'(wdata), 64'hFFFFFF85);
  endtask

  task automatic t_cp2;
    op(0, 1, 3'd4, 5'd7, 5'd0, 5'd3, 1, 3'd0, 2'd0, 0, 0);
    chk("R5", "cp2 data bank", 64'(bank), 7);
    chk("R5", "cp2 data index", 64'(idx), 103);
    chk("R9", "cp2 data upper", 64'(rdata), 64'h13579BDF);
    op(1, 1, 3'd5, 5'd0, 5'd2, 5'd1, 1, 3'd0, 2'd0, 0, 32'h1);
    chk("R5", "cp2 control bank", 64'(bank), 8);
    chk("R5", "cp2 control index", 64'(idx), 34);
    chk("R9", "cp2 control half flag", 64'(half), 0);
  endtask

  task automatic t_reserved;
    op(0, 1, 3'd1, 5'd3, 5'd0, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R11", "part 3 flag", 64'(rsvd), 1);
    chk("R11", "part 3 read", 64'(rdata), 0);
    chk("R11", "part 3 bank", 64'(bank), 0);
    op(0, 1, 3'd1, 5'd17, 5'd0, 5'd0, 0, 3'd0, 2'd0, 0, 0);
    chk("R11", "number 17 flag", 64'(rsvd), 1);
    op(1, 1, 3'd6, 5'd0, 5'd1, 5'd0, 0, 3'd0, 2'd0, 0, 32'h55);
    chk("R11", "sel 6 write dropped", 64'(we), 0);
    chk("R11", "sel 6 flag", 64'(rsvd), 1);
  endtask

  task automatic t_deny;
    op(0, 1, 3'd0, 5'd1, 5'd0, 5'd0, 0, 3'd1, 2'd0, 0, 0);
    chk("R6", "foreign read ones", 64'(rdata), 64'hFFFFFFFF);
    chk("R6", "foreign read bank", 64'(bank), 0);
    op(1, 1, 3'd0, 5'd0, 5'd1, 5'd0, 0, 3'd1, 2'd0, 0, 32'h77);
    chk("R7", "foreign write dropped", 64'(we), 0);
    op(0, 1, 3'd0, 5'd1, 5'd0, 5'd0, 0, 3'd6, 2'd0, 1, 0);
    chk("R6", "out of range read ones", 64'(rdata), 64'hFFFFFFFF);
    op(1, 0, 3'd0, 5'd0, 5'd1, 5'd0, 0, 3'd7, 2'd0, 1, 32'h77);
    chk("R7", "out of range write dropped", 64'(we), 0);
    op(0, 1, 3'd0, 5'd1, 5'd0, 5'd0, 0, 3'd5, 2'd0, 1, 0);
    chk("R12", "master reads foreign", 64'(bank), 2);
    chk("R12", "master context out", 64'(tc), 5);
    chk("R12", "master data", 64'(rdata), 64'h2468AC9C);
    op(0, 1, 3'd0, 5'd1, 5'd0, 5'd0, 0, 3'd2, 2'd0, 0, 0);
    chk("R6", "own-VPE context allowed", 64'(bank), 2);
    op(0, 1, 3'd1, 5'd3, 5'd0, 5'd0, 0, 3'd6, 2'd0, 1, 0);
    chk("R6", "denied over reserved", 64'(rdata), 64'hFFFFFFFF);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R1", "idle we", 64'(we), 0);
    chk("R1", "idle rvalid", 64'(rvalid), 0);
    chk("R1", "idle rdata", 64'(rdata), 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int t = 0; t < 8; t++) tc_bind[t*2 +: 2] = 2'(t & 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_system();
    t_gpr_fp();
    t_acc();
    t_cp2();
    t_reserved();
    t_deny();
    t_idle();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule